// File: doc/BRIEF.md
# Latched Serial-to-Parallel Shift Register

The block takes a serial bit stream on one clock and presents it as a parallel byte on a second clock. A chain of eight shift stages advances on each rising edge of the shift clock. Stage 0 takes the serial input, and the last stage drives a serial cascade output. A separate storage register copies the whole chain on each rising edge of the storage clock. The parallel outputs therefore hold steady while the next word is being shifted in.

An active-low asynchronous clear zeroes the shift stages only. An active-low output enable places the eight parallel outputs in high impedance. The enable and the latched data are also brought out as plain signals, so that enclosing logic can build its own bus driver. To build a longer chain, the cascade output of one instance drives the serial input of the next, and all instances share both clocks.

Top module: `latched_sipo`

## Requirements
- R1: While rst_ni is low, every shift stage is zero at once, without waiting for a clock, and ser_o is 0. A shift-clock edge during the clear changes nothing.
- R2: On a rising shift_clk_i edge with rst_ni high, stage k takes the old value of stage k-1 and stage 0 takes ser_i. Shifting a byte in MSB first for eight edges therefore leaves the byte in the stages with bit k in stage k.
- R3: ser_o always equals the last stage (stage 7), whatever oe_ni is.
- R4: On a rising store_clk_i edge the storage register copies the shift stages. par_q_o changes only on that edge, and shift edges alone leave it unchanged.
- R5: The clear leaves the storage register unchanged. par_q_o keeps the old value until the next storage edge, which then loads the cleared stages (all zeros).
- R6: With oe_ni high, par_o is all high impedance and par_oe_o is 0. With oe_ni low, par_o equals par_q_o and par_oe_o is 1.
- R7: When both clocks rise on the same edge, the storage register receives the stage contents from before that edge, so it lags the shifter by one pulse.
- R8: When ser_o of one instance drives ser_i of a second and both share the clocks, a bit leaves the first instance and enters stage 0 of the second on the next shift edge. Sixteen shifts fill the pair as one 16-bit chain, with the first-shifted byte in the second instance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk_i | input | 1 | Shift clock, rising edge |
| store_clk_i | input | 1 | Storage clock, rising edge |
| rst_ni | input | 1 | Asynchronous clear of the shift stages, active low |
| oe_ni | input | 1 | Parallel output enable, active low |
| ser_i | input | 1 | Serial data input |
| par_o | output | 8 | Three-state parallel outputs |
| par_q_o | output | 8 | Latched data, always driven |
| par_oe_o | output | 1 | Output driver enable (1 = par_o driven) |
| ser_o | output | 1 | Serial cascade output from the last stage |

## Verification
Two functions can meet on the same edge. A shift and a storage load can share one rising edge, and a clear can overlap a shift edge. The bench pulses both clocks in the same time step and expects the stored byte to be the stage contents from before that edge, not after it. It also pulses the shift clock while the clear is held with ser_i at 1, and expects ser_o to stay 0 and the stored byte to stay as it was until a later storage edge loads zeros.

// File: rtl/latched_sipo_pkg.sv
package latched_sipo_pkg;
  localparam int unsigned DEF_W = 8;
endpackage

// File: rtl/lsr_shift_chain.sv
module lsr_shift_chain #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ser_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int unsigned LAST = WIDTH - 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o[0] <= 1'b0;
    else         q_o[0] <= ser_i;
  end

  for (genvar k = 1; k <= LAST; k++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o[k] <= 1'b0;
      else         q_o[k] <= q_o[k-1];
    end
  end

  // set once a shift edge has been seen since the last clear
  logic primed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed <= 1'b0;
    else         primed <= 1'b1;
  end

  a_r2_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed |-> q_o[LAST:1] == $past(q_o[LAST-1:0]));

  a_r2_head: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed |-> q_o[0] == $past(ser_i));
endmodule

// File: rtl/lsr_store.sv
module lsr_store #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  // not cleared: holds the last word across a shifter clear
  always_ff @(posedge clk_i) q_o <= d_i;
endmodule

// File: rtl/lsr_out_drv.sv
module lsr_out_drv #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             oe_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] d_o,
  output logic             en_o
);
  assign en_o = ~oe_ni;
  assign d_o  = d_i;
endmodule

// File: rtl/latched_sipo.sv
module latched_sipo
  import latched_sipo_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_W
) (
  input  logic             shift_clk_i,
  input  logic             store_clk_i,
  input  logic             rst_ni,
  input  logic             oe_ni,
  input  logic             ser_i,
  output wire  [WIDTH-1:0] par_o,
  output logic [WIDTH-1:0] par_q_o,
  output logic             par_oe_o,
  output logic             ser_o
);
  localparam int unsigned LAST = WIDTH - 1;

  logic [WIDTH-1:0] shift_q;
  logic [WIDTH-1:0] store_q;
  logic [WIDTH-1:0] drv_d;
  logic             drv_en;

  lsr_shift_chain #(.WIDTH(WIDTH)) u_chain (
    .clk_i (shift_clk_i),
    .rst_ni(rst_ni),
    .ser_i (ser_i),
    .q_o   (shift_q)
  );

  lsr_store #(.WIDTH(WIDTH)) u_store (
    .clk_i(store_clk_i),
    .d_i  (shift_q),
    .q_o  (store_q)
  );

  lsr_out_drv #(.WIDTH(WIDTH)) u_drv (
    .oe_ni(oe_ni),
    .d_i  (store_q),
    .d_o  (drv_d),
    .en_o (drv_en)
  );

  assign par_q_o  = drv_d;
  assign par_oe_o = drv_en;
  assign par_o    = drv_en ? drv_d : 'z;
  assign ser_o    = shift_q[LAST];

  a_r4_load: assert property (@(posedge store_clk_i) disable iff (!rst_ni)
    1'b1 |=> par_q_o == $past(shift_q));

  a_r6_hiz: assert property (@(posedge store_clk_i) disable iff (!rst_ni)
    oe_ni |-> !par_oe_o);

  a_r6_drive: assert property (@(posedge store_clk_i) disable iff (!rst_ni)
    !oe_ni |-> par_oe_o && par_o == par_q_o);
endmodule

// File: tb/latched_sipo_bench.sv
module latched_sipo_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = CLK_PERIOD / 2;
  localparam int NVEC       = 6;
  // {oe_n, byte}
  localparam logic [8:0] VEC [NVEC] = '{9'h0A5, 9'h13C, 9'h0FF, 9'h000, 9'h181, 9'h05A};

  logic shift_clk, store_clk, rst_n, oe_n, ser;
  wire  [7:0] par_a, par_b;
  logic [7:0] q_a, q_b;
  logic       en_a, en_b, so_a, so_b;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  latched_sipo u_latched_sipo (
    .shift_clk_i(shift_clk), .store_clk_i(store_clk), .rst_ni(rst_n),
    .oe_ni(oe_n), .ser_i(ser), .par_o(par_a), .par_q_o(q_a),
    .par_oe_o(en_a), .ser_o(so_a)
  );

  latched_sipo u_latched_sipo_b (
    .shift_clk_i(shift_clk), .store_clk_i(store_clk), .rst_ni(rst_n),
    .oe_ni(oe_n), .ser_i(so_a), .par_o(par_b), .par_q_o(q_b),
    .par_oe_o(en_b), .ser_o(so_b)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse(input bit sh, input bit st, input logic d);
    ser = d;
    #HALF;
    shift_clk = sh;
    store_clk = st;
    #HALF;
    shift_clk = 0;
    store_clk = 0;
  endtask

  task automatic shift_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) pulse(1, 0, b[i]);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] prev;
    bit         have_prev;
    shift_clk = 0; store_clk = 0; rst_n = 0; oe_n = 1; ser = 0;
    #(CLK_PERIOD);
    chk("R1 reset ser_o", {15'd0, so_a}, 16'd0);
    chk("R6 reset enable", {15'd0, en_a}, 16'd0);
    rst_n = 1;
    #(CLK_PERIOD);

    // vector table: R2 R3 R4 R6
    have_prev = 0;
    prev      = '0;
    for (int v = 0; v < NVEC; v++) begin
      oe_n = VEC[v][8];
      shift_byte(VEC[v][7:0]);
      #1;
      if (have_prev) chk("R4 held during shift", {8'd0, q_a}, {8'd0, prev});
      chk("R3 ser_o last stage", {15'd0, so_a}, {15'd0, VEC[v][7]});
      pulse(0, 1, 1'b0);
      #1;
      chk("R2 R4 stored byte", {8'd0, q_a}, {8'd0, VEC[v][7:0]});
      chk("R6 enable", {15'd0, en_a}, {15'd0, ~VEC[v][8]});
      if (!VEC[v][8]) chk("R6 driven value", {8'd0, par_a}, {8'd0, VEC[v][7:0]});
      prev      = VEC[v][7:0];
      have_prev = 1;
    end
    oe_n = 0;

    // R7: tied clocks, storage gets pre-edge contents
    pulse(1, 0, 1'b0);              // stages 5A -> B4
    #1;
    chk("R4 shift only keeps store", {8'd0, q_a}, 16'h005A);
    pulse(1, 1, 1'b1);              // store B4, stages 69
    #1;
    chk("R7 tied clocks lag 1", {8'd0, q_a}, 16'h00B4);
    pulse(1, 1, 1'b0);              // store 69, stages D2
    #1;
    chk("R7 tied clocks lag 2", {8'd0, q_a}, 16'h0069);
    chk("R3 ser_o before clear", {15'd0, so_a}, 16'd1);

    // R1 R5: clear is asynchronous and spares the storage register
    rst_n = 0;
    #1;
    chk("R1 async clear ser_o", {15'd0, so_a}, 16'd0);
    chk("R5 store kept on clear", {8'd0, q_a}, 16'h0069);
    pulse(1, 0, 1'b1);
    #1;
    chk("R1 shift ignored in clear", {15'd0, so_a}, 16'd0);
    rst_n = 1;
    #1;
    chk("R5 store kept after clear", {8'd0, q_a}, 16'h0069);
    pulse(0, 1, 1'b0);
    #1;
    chk("R5 R1 zeros loaded", {8'd0, q_a}, 16'h0000);

    // R8: two instances as one 16-bit chain
    shift_byte(8'hA5);
    pulse(0, 1, 1'b0);
    #1;
    chk("R8 second empty after 8", {8'd0, q_b}, 16'h0000);
    shift_byte(8'h3C);
    pulse(0, 1, 1'b0);
    #1;
    chk("R8 chain 16 bits", {q_b, q_a}, 16'hA53C);
    chk("R8 second driven", {8'd0, par_b}, 16'h00A5);
    chk("R3 second ser_o", {15'd0, so_b}, 16'd1);
    oe_n = 1;
    #1;
    chk("R6 disabled second", {15'd0, en_b}, 16'd0);
    chk("R3 ser_o ignores oe", {15'd0, so_a}, 16'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule